// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block runs one analog measurement for a small coprocessor on each command it accepts. A command names one of two converters, a pad mux code and one of four destination registers. Once the block accepts the command it latches the command and its timing configuration. It then walks a fixed-order schedule: a fixed setup interval, three amplifier settle intervals, a sample interval and a bit-conversion interval. In the last step it writes the converter's result word into the chosen register and pulses `done`. After that it holds off new commands for a short fetch interval.

The schedule lasts 23 fixed cycles plus the sum of the three settle times, the sample time and the bit time. A settle time programmed as zero still takes one cycle. The pad mux code is one-based: code 1 enables pad 0 and code k enables pad k-1. Code 0 names no pad, so the command ends at once with an error flag and changes no register. The result registers can be read at any time through a combinational read port.

States: `ST_IDLE`, `ST_SETUP`, `ST_AMP1`, `ST_AMP2`, `ST_AMP3`, `ST_SAMPLE`, `ST_CONVERT`, `ST_WRITE`, `ST_BADPAD`, `ST_FETCH`.

Transitions:
- IDLE to SETUP when a start arrives with a valid code.
- IDLE to BADPAD when a start arrives with code 0.
- SETUP to AMP1 to AMP2 to AMP3, each step when its interval expires.
- AMP3 to SAMPLE when the sample time is non-zero. Otherwise AMP3 goes to CONVERT when the bit time is non-zero, and to WRITE when both are zero.
- SAMPLE to CONVERT when the bit time is non-zero, otherwise to WRITE.
- CONVERT to WRITE.
- WRITE to FETCH and BADPAD to FETCH.
- FETCH to IDLE after 4 cycles.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `conv_en` and `pad_en` are 0, `ready` is 1, and all four result registers read 0.
- R2: For a valid command accepted at a clock edge, `done` is high in exactly the N-th cycle after that edge. N = 23 + max(1,amp1) + max(1,amp2) + max(1,amp3) + sample + bits.
- R3: An amplifier settle time of 0 counts as one cycle in the total of R2.
- R4: During SETUP through CONVERT, `pad_en` is one-hot with bit (mux-1) set, so mux 1 enables bit 0. In every other cycle `pad_en` is 0.
- R5: `conv_sel` equals the latched select bit (0 = converter 0, 1 = converter 1) while `pad_en` is non-zero, and is 0 otherwise. `conv_en` is high for exactly sample + bits cycles of a command.
- R6: On completion, register `dst` (0..3) receives the zero-extended `conv_result`, and the other registers keep their values.
- R7: A command with mux code 0 raises `done` and `err` together for one cycle, in the first cycle after acceptance. It drives no pad and no conversion, and writes no register.
- R8: A start that arrives while `busy` is high, or during the fetch hold-off, is ignored. It does not change the running command's timing or destination, and it starts no new command.
- R9: After the `done` cycle, `ready` stays low and `busy` stays low for exactly 4 cycles, then `ready` returns high.
- R10: The five timing inputs are sampled only at acceptance. Changing them during a command does not alter its timing.
- R11: `busy` stays high from the cycle after acceptance through the `done` cycle without a gap, and `done` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Command strobe, taken when `ready` is high |
| cmd_sel | input | 1 | Converter select |
| cmd_mux | input | MUX_W | One-based pad mux code, 0 is invalid |
| cmd_dst | input | IDX_W | Destination register index |
| cfg_amp1 | input | WAIT_W | First amplifier settle time |
| cfg_amp2 | input | WAIT_W | Second amplifier settle time |
| cfg_amp3 | input | WAIT_W | Third amplifier settle time |
| cfg_sample | input | SAMP_W | Sample interval length |
| cfg_bits | input | SAMP_W | Bit-conversion interval length |
| conv_result | input | RES_W | Converter result word |
| conv_en | output | 1 | Converter active (sample and bit phases) |
| conv_sel | output | 1 | Selected converter |
| pad_en | output | NUM_PADS | One-hot pad enable |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Invalid pad code, with `done` |
| ready | output | 1 | A start would be accepted |
| rd_idx | input | IDX_W | Result register read index |
| rd_data | output | DATA_W | Result register read data |

## Verification
A table of commands drives the schedule with different timing inputs:
- all settle times zero and no sample or bit time, which isolates the clamping and the skipped phases;
- mixed non-zero values, which check that each term adds once;
- a settle time at its maximum, which checks the counter width;
- sample-only and bits-only settings, which tell the two skip paths apart.

Mux codes 1, 2, 8 and 15 separate an off-by-one in the pad decode from a correct one. Directed cases cover code 0, starts during a conversion and during the hold-off, and timing inputs that change after acceptance.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_AMP1,
        ST_AMP2,
        ST_AMP3,
        ST_SAMPLE,
        ST_CONVERT,
        ST_WRITE,
        ST_BADPAD,
        ST_FETCH
    } seq_state_e;

    // fixed overhead of a conversion, including the writeback cycle
    localparam int unsigned FIXED_CYCLES = 23;
    // hold-off before the next command may be taken
    localparam int unsigned FETCH_CYCLES = 4;

endpackage

// File: rtl/adcseq_phase_timer.sv
module adcseq_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);

    // R2
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/adcseq_pad_decoder.sv
module adcseq_pad_decoder #(
    parameter int MUX_W    = 4,
    parameter int NUM_PADS = 15
) (
    input  logic [MUX_W-1:0]    mux_code,
    output logic [NUM_PADS-1:0] pad_onehot,
    output logic                code_valid
);

    // one-based code: code k selects pad k-1, code 0 selects nothing
    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        assign pad_onehot[p] = (mux_code == MUX_W'(p + 1));
    end

    assign code_valid = |pad_onehot;

endmodule

// File: rtl/adcseq_regfile.sv
module adcseq_regfile #(
    parameter int NREG   = 4,
    parameter int DATA_W = 16,
    parameter int IDX_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] regs_q [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[r] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(r))) begin
                regs_q[r] <= wr_data;
            end
        end
    end

    assign rd_data = regs_q[rd_idx];

endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
    import adcseq_pkg::*;
#(
    parameter int WAIT_W   = 8,
    parameter int SAMP_W   = 8,
    parameter int NUM_PADS = 15,
    parameter int IDX_W    = 2,
    parameter int CNT_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_start,
    input  logic                cmd_sel,
    input  logic [IDX_W-1:0]    cmd_dst,
    input  logic [NUM_PADS-1:0] pad_code,
    input  logic                pad_ok,
    input  logic [WAIT_W-1:0]   cfg_amp1,
    input  logic [WAIT_W-1:0]   cfg_amp2,
    input  logic [WAIT_W-1:0]   cfg_amp3,
    input  logic [SAMP_W-1:0]   cfg_sample,
    input  logic [SAMP_W-1:0]   cfg_bits,
    input  logic                tmr_expired,
    output logic                tmr_load,
    output logic [CNT_W-1:0]    tmr_val,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic                ready,
    output logic                conv_en,
    output logic                conv_sel,
    output logic [NUM_PADS-1:0] pad_en,
    output logic                wr_en,
    output logic [IDX_W-1:0]    wr_idx
);

    seq_state_e state_q, state_n;

    logic                accept;
    logic                sel_q;
    logic [IDX_W-1:0]    dst_q;
    logic [NUM_PADS-1:0] pad_q;
    logic [WAIT_W-1:0]   amp1_q, amp2_q, amp3_q;
    logic [SAMP_W-1:0]   samp_q, bits_q;
    logic                pad_phase;

    assign accept = (state_q == ST_IDLE) && cmd_start;

    // settle time reload value: a zero setting still lasts one cycle
    function automatic logic [CNT_W-1:0] amp_reload(input logic [WAIT_W-1:0] a);
        return (a == '0) ? '0 : (CNT_W'(a) - CNT_W'(1));
    endfunction

    // cycles-minus-one spent in the state being entered
    function automatic logic [CNT_W-1:0] reload_for(input seq_state_e s);
        unique case (s)
            ST_SETUP:   return CNT_W'(FIXED_CYCLES - 2);
            ST_AMP1:    return amp_reload(amp1_q);
            ST_AMP2:    return amp_reload(amp2_q);
            ST_AMP3:    return amp_reload(amp3_q);
            ST_SAMPLE:  return CNT_W'(samp_q) - CNT_W'(1);
            ST_CONVERT: return CNT_W'(bits_q) - CNT_W'(1);
            ST_FETCH:   return CNT_W'(FETCH_CYCLES - 1);
            default:    return '0;
        endcase
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // command capture, only at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            dst_q  <= '0;
            pad_q  <= '0;
            amp1_q <= '0;
            amp2_q <= '0;
            amp3_q <= '0;
            samp_q <= '0;
            bits_q <= '0;
        end else if (accept) begin
            sel_q  <= cmd_sel;
            dst_q  <= cmd_dst;
            pad_q  <= pad_code;
            amp1_q <= cfg_amp1;
            amp2_q <= cfg_amp2;
            amp3_q <= cfg_amp3;
            samp_q <= cfg_sample;
            bits_q <= cfg_bits;
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_start) begin
                    state_n = pad_ok ? ST_SETUP : ST_BADPAD;
                end
            end
            ST_SETUP: begin
                if (tmr_expired) state_n = ST_AMP1;
            end
            ST_AMP1: begin
                if (tmr_expired) state_n = ST_AMP2;
            end
            ST_AMP2: begin
                if (tmr_expired) state_n = ST_AMP3;
            end
            ST_AMP3: begin
                if (tmr_expired) begin
                    if (samp_q != '0)      state_n = ST_SAMPLE;
                    else if (bits_q != '0) state_n = ST_CONVERT;
                    else                   state_n = ST_WRITE;
                end
            end
            ST_SAMPLE: begin
                if (tmr_expired) begin
                    state_n = (bits_q != '0) ? ST_CONVERT : ST_WRITE;
                end
            end
            ST_CONVERT: begin
                if (tmr_expired) state_n = ST_WRITE;
            end
            ST_WRITE:  state_n = ST_FETCH;
            ST_BADPAD: state_n = ST_FETCH;
            ST_FETCH: begin
                if (tmr_expired) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign tmr_load = (state_n != state_q);
    assign tmr_val  = reload_for(state_n);

    // outputs
    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        err       = 1'b0;
        ready     = 1'b0;
        conv_en   = 1'b0;
        wr_en     = 1'b0;
        pad_phase = 1'b0;
        unique case (state_q)
            ST_IDLE:  ready = 1'b1;
            ST_SETUP, ST_AMP1, ST_AMP2, ST_AMP3: begin
                busy      = 1'b1;
                pad_phase = 1'b1;
            end
            ST_SAMPLE, ST_CONVERT: begin
                busy      = 1'b1;
                pad_phase = 1'b1;
                conv_en   = 1'b1;
            end
            ST_WRITE: begin
                busy  = 1'b1;
                done  = 1'b1;
                wr_en = 1'b1;
            end
            ST_BADPAD: begin
                busy = 1'b1;
                done = 1'b1;
                err  = 1'b1;
            end
            ST_FETCH: ;
            default: ;
        endcase
    end

    assign pad_en   = pad_phase ? pad_q : '0;
    assign conv_sel = pad_phase & sel_q;
    assign wr_idx   = dst_q;

    // R11
    // done lasts a single cycle
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R9
    fetch_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!ready && !busy));

    // R4
    pad_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pad_en));

    // R5
    conv_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_en |-> (busy && !done));

    // R8
    ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && cmd_start) |=> ($stable(dst_q) && $stable(sel_q) && $stable(pad_q)));

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(amp1_q) && $stable(amp2_q) && $stable(amp3_q)
                                 && $stable(samp_q) && $stable(bits_q)));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adcseq_pkg::*;
#(
    parameter int MUX_W    = 4,
    parameter int NUM_PADS = (1 << MUX_W) - 1,
    parameter int NREG     = 4,
    parameter int IDX_W    = $clog2(NREG),
    parameter int DATA_W   = 16,
    parameter int RES_W    = 12,
    parameter int WAIT_W   = 8,
    parameter int SAMP_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_start,
    input  logic                cmd_sel,
    input  logic [MUX_W-1:0]    cmd_mux,
    input  logic [IDX_W-1:0]    cmd_dst,
    input  logic [WAIT_W-1:0]   cfg_amp1,
    input  logic [WAIT_W-1:0]   cfg_amp2,
    input  logic [WAIT_W-1:0]   cfg_amp3,
    input  logic [SAMP_W-1:0]   cfg_sample,
    input  logic [SAMP_W-1:0]   cfg_bits,
    input  logic [RES_W-1:0]    conv_result,
    output logic                conv_en,
    output logic                conv_sel,
    output logic [NUM_PADS-1:0] pad_en,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic                ready,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [DATA_W-1:0]   rd_data
);

    localparam int WMAX  = (WAIT_W > SAMP_W) ? WAIT_W : SAMP_W;
    localparam int CNT_W = (WMAX > 5) ? WMAX : 5;

    logic [NUM_PADS-1:0] pad_code;
    logic                pad_ok;
    logic                tmr_load;
    logic [CNT_W-1:0]    tmr_val;
    logic                tmr_expired;
    logic                wr_en;
    logic [IDX_W-1:0]    wr_idx;
    logic [DATA_W-1:0]   wr_data;

    adcseq_pad_decoder #(
        .MUX_W    (MUX_W),
        .NUM_PADS (NUM_PADS)
    ) u_dec (
        .mux_code   (cmd_mux),
        .pad_onehot (pad_code),
        .code_valid (pad_ok)
    );

    adcseq_fsm #(
        .WAIT_W   (WAIT_W),
        .SAMP_W   (SAMP_W),
        .NUM_PADS (NUM_PADS),
        .IDX_W    (IDX_W),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_start   (cmd_start),
        .cmd_sel     (cmd_sel),
        .cmd_dst     (cmd_dst),
        .pad_code    (pad_code),
        .pad_ok      (pad_ok),
        .cfg_amp1    (cfg_amp1),
        .cfg_amp2    (cfg_amp2),
        .cfg_amp3    (cfg_amp3),
        .cfg_sample  (cfg_sample),
        .cfg_bits    (cfg_bits),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .busy        (busy),
        .done        (done),
        .err         (err),
        .ready       (ready),
        .conv_en     (conv_en),
        .conv_sel    (conv_sel),
        .pad_en      (pad_en),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx)
    );

    adcseq_phase_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    assign wr_data = DATA_W'(conv_result);

    adcseq_regfile #(
        .NREG   (NREG),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    // R7
    badpad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!wr_en && !conv_en && pad_en == '0 && done));

    // R6
    write_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (done && !err));

endmodule

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;

    typedef struct packed {
        logic        sel;
        logic [3:0]  mux;
        logic [1:0]  dst;
        logic [7:0]  a1;
        logic [7:0]  a2;
        logic [7:0]  a3;
        logic [7:0]  samp;
        logic [7:0]  bits;
        logic [11:0] res;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 4'd1,  2'd0, 8'd0,   8'd0, 8'd0, 8'd0, 8'd0,  12'hABC},
        '{1'b1, 4'd2,  2'd1, 8'd1,   8'd2, 8'd3, 8'd4, 8'd12, 12'h123},
        '{1'b0, 4'd15, 2'd2, 8'd5,   8'd0, 8'd7, 8'd0, 8'd10, 12'hFFF},
        '{1'b1, 4'd8,  2'd3, 8'd0,   8'd9, 8'd0, 8'd3, 8'd0,  12'h055},
        '{1'b0, 4'd3,  2'd1, 8'd255, 8'd1, 8'd1, 8'd2, 8'd2,  12'h800}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic        cmd_sel = 1'b0;
    logic [3:0]  cmd_mux = '0;
    logic [1:0]  cmd_dst = '0;
    logic [7:0]  cfg_amp1 = '0, cfg_amp2 = '0, cfg_amp3 = '0;
    logic [7:0]  cfg_sample = '0, cfg_bits = '0;
    logic [11:0] conv_result = '0;
    logic        conv_en, conv_sel, busy, done, err, ready;
    logic [14:0] pad_en;
    logic [1:0]  rd_idx = '0;
    logic [15:0] rd_data;

    int n_checks = 0;
    int n_fail = 0;
    logic [15:0] model [4];

    always #4 clk = ~clk;

    adc_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_sel(cmd_sel),
        .cmd_mux(cmd_mux), .cmd_dst(cmd_dst), .cfg_amp1(cfg_amp1),
        .cfg_amp2(cfg_amp2), .cfg_amp3(cfg_amp3), .cfg_sample(cfg_sample),
        .cfg_bits(cfg_bits), .conv_result(conv_result), .conv_en(conv_en),
        .conv_sel(conv_sel), .pad_en(pad_en), .busy(busy), .done(done),
        .err(err), .ready(ready), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int clamp1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int exp_latency(input vec_t v);
        return 23 + clamp1(int'(v.a1)) + clamp1(int'(v.a2)) + clamp1(int'(v.a3))
                  + int'(v.samp) + int'(v.bits);
    endfunction

    task automatic check_regs(input string req);
        for (int r = 0; r < 4; r++) begin
            rd_idx = 2'(r);
            #1;
            check(rd_data == model[r], req, int'(rd_data), int'(model[r]));
        end
    endtask

    // issues one command and follows it to done
    task automatic run_cmd(input vec_t v, input int inject_at, input bit scramble,
                           output int lat, output int conv_cnt, output int pad_cnt,
                           output bit pad_bad, output bit sel_bad, output bit err_seen,
                           output bit gap);
        logic [14:0] exp_pad;
        exp_pad = (v.mux == 0) ? 15'd0 : (15'd1 << (v.mux - 1));
        lat = -1; conv_cnt = 0; pad_cnt = 0;
        pad_bad = 0; sel_bad = 0; err_seen = 0; gap = 0;
        @(negedge clk);
        cmd_sel = v.sel; cmd_mux = v.mux; cmd_dst = v.dst;
        cfg_amp1 = v.a1; cfg_amp2 = v.a2; cfg_amp3 = v.a3;
        cfg_sample = v.samp; cfg_bits = v.bits; conv_result = v.res;
        cmd_start = 1'b1;
        @(negedge clk);
        for (int k = 1; k <= 4000; k++) begin
            if (k == 1) begin
                cmd_start = 1'b0;
                if (scramble) begin
                    cfg_amp1 = 8'd40; cfg_amp2 = 8'd0; cfg_amp3 = 8'd90;
                    cfg_sample = 8'd0; cfg_bits = 8'd33;
                end
            end
            if (inject_at == k) begin
                cmd_start = 1'b1; cmd_dst = v.dst + 2'd1; cmd_mux = 4'd5; cmd_sel = ~v.sel;
            end else if (inject_at == k - 1) begin
                cmd_start = 1'b0;
            end
            if (!busy) begin gap = 1; break; end
            if (pad_en == exp_pad) pad_cnt++;
            else if (pad_en != '0) pad_bad = 1;
            if (conv_en) conv_cnt++;
            if (conv_sel != ((pad_en != '0) ? v.sel : 1'b0)) sel_bad = 1;
            if (done) begin lat = k; err_seen = err; break; end
            @(negedge clk);
        end
        cmd_start = 1'b0;
    endtask

    // counts cycles with ready low after done; busy must stay low
    task automatic wait_fetch(output int low_cnt, output bit busy_seen);
        low_cnt = 0; busy_seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (busy) busy_seen = 1;
            if (ready) break;
            low_cnt++;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int lat, cc, pc, fl;
        bit pb, sb, es, gp, bs;
        vec_t v;
        for (int r = 0; r < 4; r++) model[r] = '0;

        // R1 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !err, "R1 flags", int'({busy, done, err}), 0);
        check(ready, "R1 ready", int'(ready), 1);
        check(pad_en == '0 && !conv_en, "R1 pad/conv", int'(pad_en), 0);
        check_regs("R1 regs");

        // table walk: R2 R3 R4 R5 R6 R9 R11
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            run_cmd(v, 0, 1'b0, lat, cc, pc, pb, sb, es, gp);
            check(lat == exp_latency(v), "R2 R3 latency", lat, exp_latency(v));
            check(!gp, "R11 busy continuous", int'(gp), 0);
            check(!pb && pc == exp_latency(v) - 1, "R4 pad enable", pc, exp_latency(v) - 1);
            check(!sb, "R5 converter select", int'(sb), 0);
            check(cc == int'(v.samp) + int'(v.bits), "R5 conv_en cycles", cc,
                  int'(v.samp) + int'(v.bits));
            check(!es, "R7 no err on valid code", int'(es), 0);
            @(negedge clk);
            check(!done, "R11 done single", int'(done), 0);
            check(!ready && !busy, "R9 holdoff start", int'(ready), 0);
            wait_fetch(fl, bs);
            check(fl == 3 && !bs, "R9 holdoff length", fl + 1, 4);
            model[v.dst] = {4'd0, v.res};
            check_regs("R6 writeback");
        end

        // R7 mux code 0
        v = '{1'b1, 4'd0, 2'd2, 8'd3, 8'd3, 8'd3, 8'd5, 8'd5, 12'h777};
        run_cmd(v, 0, 1'b0, lat, cc, pc, pb, sb, es, gp);
        check(lat == 1, "R7 error latency", lat, 1);
        check(es, "R7 err with done", int'(es), 1);
        check(!pb && cc == 0, "R7 no pad or conversion", cc, 0);
        wait_fetch(fl, bs);
        check(fl == 4, "R9 holdoff after error", fl, 4);
        check_regs("R7 no write");

        // R8 start while busy ignored
        v = VEC[3];
        v.res = 12'h3C3;
        run_cmd(v, 6, 1'b0, lat, cc, pc, pb, sb, es, gp);
        check(lat == exp_latency(v), "R8 latency unchanged", lat, exp_latency(v));
        check(!pb && !sb, "R8 pad/sel unchanged", int'({pb, sb}), 0);
        wait_fetch(fl, bs);
        check(!bs, "R8 no second command", int'(bs), 0);
        model[v.dst] = {4'd0, v.res};
        check_regs("R8 destination kept");

        // R10 config changed after acceptance
        v = VEC[1];
        v.res = 12'h9A9;
        run_cmd(v, 0, 1'b1, lat, cc, pc, pb, sb, es, gp);
        check(lat == exp_latency(v), "R10 latency from latched cfg", lat, exp_latency(v));
        check(cc == int'(v.samp) + int'(v.bits), "R10 conv cycles", cc,
              int'(v.samp) + int'(v.bits));
        wait_fetch(fl, bs);
        model[v.dst] = {4'd0, v.res};
        check_regs("R10 writeback");

        // R8 start during hold-off ignored
        v = VEC[0];
        v.res = 12'h111;
        run_cmd(v, 0, 1'b0, lat, cc, pc, pb, sb, es, gp);
        @(negedge clk);
        @(negedge clk);
        cmd_mux = 4'd5; cmd_dst = 2'd3; conv_result = 12'h0EE; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        bs = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (busy) bs = 1;
        end
        check(!bs, "R8 start in holdoff", int'(bs), 0);
        check(ready, "R9 ready after holdoff", int'(ready), 1);
        model[v.dst] = {4'd0, v.res};
        check_regs("R8 holdoff regs");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule